// File: doc/BRIEF.md
# Multiplexed LED Scan Engine with PWM Brightness

This block drives a common-cathode LED display of up to eight digits through nine shared pins. It works through the digits one at a time. Each digit gets a slot of fixed length. During that slot, one pin sinks current as that digit's cathode, and the pins that carry lit segments source current. Every other pin is left floating.

The pin assignment rotates from digit to digit. Digit k always has its cathode on pin k. The eight segment lines fill the remaining pins in ascending order, skipping pin k. Because of this, no two digits share the same segment-to-pin wiring. Each slot is divided into sixteen equal sub-steps. A 4-bit brightness code decides how many of the leading sub-steps have the drivers switched on, and the final sub-step is always dark.

The design around this block supplies the following inputs:
- a multiplex-clock enable pulse;
- the last digit to scan;
- the brightness code;
- a power-down flag;
- a lamp-test flag;
- a resynchronise pulse;
- the eight segment bits of the digit currently shown, from the decoder, read through the `digit_idx` output.

Top module: `disp_scan_mux`

## Requirements
- R1: With tick held high, a digit slot lasts SLOT_TICKS clock cycles and is split into 16 sub-steps of SLOT_TICKS/16 ticks each.
- R2: Digits are visited 0, 1, ... up to `scan_limit`, then back to 0. The limit is checked at the end of each slot, and `digit_idx` reports the digit being shown.
- R3: For brightness code n, the drivers are on during the first n+1 sub-steps of the slot, and codes 14 and 15 both give 15. Sub-step 15 is always blanked.
- R4: While digit k is driven, pin k sinks. Segment bits 7 down to 0 (dp, g, f, e, d, c, b, a) go onto pins 0 through 8 in ascending order, skipping pin k. Pin 8 never sinks.
- R5: At most one pin sinks, and only during the enabled sub-steps. A pin never sinks and sources at once. Unlit segment pins, and all pins during blanking, are high impedance (sink=0, src=0).
- R6: With `shutdown`=1 and `disp_test`=0, the scan counters stop, `digit_idx` holds, and every pin is high impedance.
- R7: With `disp_test`=1, all eight segments are lit, all eight digits are scanned, and the on-time is 7 of 16 sub-steps. This overrides `shutdown`, and the normal settings take effect again once it is released.
- R8: A `sync` pulse restarts the sequence at digit 0, sub-step 0, tick 0 on the next cycle.
- R9: The counters advance only in cycles with `mux_tick`=1.
- R10: After reset, `digit_idx`=0 and all pins are high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_tick | input | 1 | Multiplex clock enable |
| scan_limit | input | 3 | Last digit scanned (0..7) |
| intensity | input | 4 | Brightness code |
| shutdown | input | 1 | Power-down request |
| disp_test | input | 1 | Lamp test |
| sync | input | 1 | Restart scan at digit 0 |
| seg_vec | input | 8 | Segments of current digit, bit7=dp ... bit0=a |
| digit_idx | output | 3 | Digit being driven |
| pin_sink | output | 9 | Per-pin cathode sink enable |
| pin_src | output | 9 | Per-pin segment source enable |

## Verification
The scan is run in several configurations:
- A sparse segment pattern over three digits at a mid brightness. This separates correct skip-pin rotation from a plain shift, and a wrap at the limit from one that runs past it.
- A dense pattern over eight digits at codes 15 and 14, which shows the clamp and the blanked final sub-step.
- Code 0 on a single digit, which shows the minimum on-time and repeated reuse of digit 0.

Gating `mux_tick` every other cycle separates tick-driven timing from clock-driven timing. Shutdown issued mid-slot, lamp test issued while shutdown is set, and a `sync` pulse issued mid-slot each show whether the counters hold, are overridden, or restart.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;
  localparam int NSUB   = 16;
  localparam int SUB_W  = 4;
  localparam int NSEG   = 8;
  localparam int TEST_ON = 7;
  localparam int MAX_ON  = 15;

  function automatic logic [SUB_W:0] on_steps(input logic [3:0] code, input logic test);
    logic [SUB_W:0] r;
    if (test) r = (SUB_W+1)'(TEST_ON);
    else if (code >= 4'd14) r = (SUB_W+1)'(MAX_ON);
    else r = {1'b0, code} + 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/scan_timebase.sv
module scan_timebase
  import disp_scan_pkg::*;
#(
  parameter int NDIG = 8,
  parameter int SLOT_TICKS = 800,
  localparam int DIG_W = $clog2(NDIG),
  localparam int STEP = SLOT_TICKS / NSUB,
  localparam int STEP_W = (STEP > 1) ? $clog2(STEP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             sync,
  input  logic [DIG_W-1:0] limit,
  output logic [DIG_W-1:0] dig,
  output logic [SUB_W-1:0] sub
);
  logic [STEP_W-1:0] tcnt;
  logic step_end, slot_end;

  assign step_end = (tcnt == STEP_W'(STEP - 1));
  assign slot_end = step_end && (sub == SUB_W'(NSUB - 1));

  always_ff @(posedge clk) begin
    if (rst || sync) begin
      tcnt <= '0;
      sub  <= '0;
      dig  <= '0;
    end else if (run && tick) begin
      if (step_end) begin
        tcnt <= '0;
        sub  <= sub + 1'b1;
        if (slot_end) dig <= (dig >= limit) ? '0 : dig + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !sync && slot_end && dig >= limit) |=> dig == '0);
  p_sync_restart_r8: assert property (@(posedge clk) disable iff (rst)
    sync |=> (dig == '0 && sub == '0));
  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !sync) |=> ($stable(dig) && $stable(sub)));
endmodule

// File: rtl/scan_pwm_gate.sv
module scan_pwm_gate
  import disp_scan_pkg::*;
(
  input  logic [SUB_W-1:0] sub,
  input  logic [3:0]       intensity,
  input  logic             test,
  input  logic             run,
  output logic             drive_en
);
  logic [SUB_W:0] on_n;
  always_comb begin
    on_n = on_steps(intensity, test);
    drive_en = run && ({1'b0, sub} < on_n);
  end
endmodule

// File: rtl/scan_pin_router.sv
module scan_pin_router
  import disp_scan_pkg::*;
#(
  parameter int NDIG = 8,
  localparam int DIG_W = $clog2(NDIG),
  localparam int NPIN = NDIG + 1
) (
  input  logic [DIG_W-1:0] dig,
  input  logic [NSEG-1:0]  segs,
  input  logic             en,
  output logic [NPIN-1:0]  sink,
  output logic [NPIN-1:0]  src
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    if (p == NPIN - 1) begin : g_last
      assign sink[p] = 1'b0;
      assign src[p]  = en && segs[0];
    end else if (p == 0) begin : g_first
      assign sink[p] = en && (dig == '0);
      assign src[p]  = en && (dig != '0) && segs[NSEG-1];
    end else begin : g_mid
      assign sink[p] = en && (dig == DIG_W'(p));
      always_comb begin
        if (dig > DIG_W'(p))      src[p] = en && segs[NSEG-1-p];
        else if (dig < DIG_W'(p)) src[p] = en && segs[NSEG-p];
        else                      src[p] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/disp_scan_mux.sv
module disp_scan_mux
  import disp_scan_pkg::*;
#(
  parameter int NDIG = 8,
  parameter int SLOT_TICKS = 800,
  localparam int DIG_W = $clog2(NDIG),
  localparam int NPIN = NDIG + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mux_tick,
  input  logic [DIG_W-1:0] scan_limit,
  input  logic [3:0]       intensity,
  input  logic             shutdown,
  input  logic             disp_test,
  input  logic             sync,
  input  logic [NSEG-1:0]  seg_vec,
  output logic [DIG_W-1:0] digit_idx,
  output logic [NPIN-1:0]  pin_sink,
  output logic [NPIN-1:0]  pin_src
);
  logic             run;
  logic [DIG_W-1:0] lim_eff, dig;
  logic [SUB_W-1:0] sub;
  logic [NSEG-1:0]  segs_eff;
  logic             drive_en;
  logic [NPIN-1:0]  sink_c, src_c;

  assign run      = !shutdown || disp_test;
  assign lim_eff  = disp_test ? DIG_W'(NDIG - 1) : scan_limit;
  assign segs_eff = disp_test ? '1 : seg_vec;

  scan_timebase #(.NDIG(NDIG), .SLOT_TICKS(SLOT_TICKS)) u_tb (
    .clk(clk), .rst(rst), .tick(mux_tick), .run(run), .sync(sync),
    .limit(lim_eff), .dig(dig), .sub(sub));

  scan_pwm_gate u_pwm (
    .sub(sub), .intensity(intensity), .test(disp_test), .run(run),
    .drive_en(drive_en));

  scan_pin_router #(.NDIG(NDIG)) u_rt (
    .dig(dig), .segs(segs_eff), .en(drive_en), .sink(sink_c), .src(src_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      digit_idx <= '0;
      pin_sink  <= '0;
      pin_src   <= '0;
    end else begin
      digit_idx <= dig;
      pin_sink  <= sink_c;
      pin_src   <= src_c;
    end
  end

  p_one_cathode_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pin_sink));
  p_no_conflict_r5: assert property (@(posedge clk) disable iff (rst)
    (pin_sink & pin_src) == '0);
  p_blank_tail_r3: assert property (@(posedge clk) disable iff (rst)
    (sub == SUB_W'(NSUB - 1)) |=> (pin_sink == '0 && pin_src == '0));
  p_shutdown_hiz_r6: assert property (@(posedge clk) disable iff (rst)
    (shutdown && !disp_test) |=> (pin_sink == '0 && pin_src == '0));
  p_test_all_lit_r7: assert property (@(posedge clk) disable iff (rst)
    disp_test |=> ($countones(pin_src) == NSEG || pin_src == '0));
endmodule

// File: tb/sim_disp_scan_mux.sv
module sim_disp_scan_mux;
  localparam int SLOT = 32;
  localparam int STEP = SLOT / 16;

  logic clk = 1'b0;
  logic rst, mux_tick, shutdown, disp_test, sync;
  logic [2:0] scan_limit, digit_idx;
  logic [3:0] intensity;
  logic [7:0] seg_vec;
  logic [8:0] pin_sink, pin_src;

  always #2 clk = ~clk;

  disp_scan_mux #(.NDIG(8), .SLOT_TICKS(SLOT)) u0 (
    .clk(clk), .rst(rst), .mux_tick(mux_tick), .scan_limit(scan_limit),
    .intensity(intensity), .shutdown(shutdown), .disp_test(disp_test),
    .sync(sync), .seg_vec(seg_vec), .digit_idx(digit_idx),
    .pin_sink(pin_sink), .pin_src(pin_src));

  typedef struct {
    logic [2:0] d;
    logic [8:0] sk;
    logic [8:0] sr;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0;
  int m_tc = 0, m_sub = 0, m_dig = 0;
  bit done = 0;

  // driver: expected output for the coming edge, then advance model
  task automatic step(string tag);
    exp_t e;
    bit runm;
    int lim, on;
    logic [7:0] segs;
    runm = !shutdown || disp_test;
    lim  = disp_test ? 7 : int'(scan_limit);
    segs = disp_test ? 8'hFF : seg_vec;
    on   = disp_test ? 7 : ((intensity >= 14) ? 15 : int'(intensity) + 1);
    e.tag = tag; e.sk = '0; e.sr = '0; e.d = 3'(m_dig);
    if (rst) e.d = '0;
    else if (runm && m_sub < on) begin
      for (int p = 0; p < 9; p++) begin
        if (p == m_dig) e.sk[p] = 1'b1;
        else begin
          int j;
          j = (p < m_dig) ? p : p - 1;
          e.sr[p] = segs[7 - j];
        end
      end
    end
    q.push_back(e);
    if (rst || sync) begin
      m_tc = 0; m_sub = 0; m_dig = 0;
    end else if (runm && mux_tick) begin
      if (m_tc == STEP - 1) begin
        m_tc = 0;
        if (m_sub == 15) begin
          m_sub = 0;
          m_dig = (m_dig >= lim) ? 0 : m_dig + 1;
        end else m_sub++;
      end else m_tc++;
    end
    @(negedge clk);
  endtask

  task automatic run_n(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (digit_idx !== e.d || pin_sink !== e.sk || pin_src !== e.sr) begin
        n_fail++;
        $display("FAIL %s: got dig=%0d sink=%b src=%b exp dig=%0d sink=%b src=%b",
                 e.tag, digit_idx, pin_sink, pin_src, e.d, e.sk, e.sr);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; mux_tick = 1; shutdown = 1; disp_test = 0; sync = 0;
    scan_limit = 3'd4; intensity = 4'd0; seg_vec = 8'h00;
    run_n(3, "R10 reset");
    rst = 0;
    run_n(2, "R10 reset state");
    // powered down after reset
    seg_vec = 8'hA5;
    run_n(40, "R6 shutdown idle");
    // three digits, sparse pattern, mid brightness
    shutdown = 0; scan_limit = 3'd2; intensity = 4'd3;
    run_n(3 * 3 * SLOT, "R1 R2 R3 R4 R5 limit2");
    // eight digits, dense pattern, clamped codes
    scan_limit = 3'd7; intensity = 4'd15; seg_vec = 8'h3C;
    run_n(8 * SLOT + 5, "R2 R3 R4 code15");
    intensity = 4'd14; seg_vec = 8'h81;
    run_n(2 * SLOT, "R3 R4 code14");
    // gated tick
    intensity = 4'd9;
    for (int i = 0; i < 3 * SLOT; i++) begin
      mux_tick = i[0];
      step("R9 gated tick");
    end
    mux_tick = 1;
    // shutdown mid-slot, then resume
    run_n(7, "R1 pre-shutdown");
    shutdown = 1;
    run_n(50, "R6 shutdown hold");
    shutdown = 0;
    run_n(SLOT, "R6 resume");
    // lamp test overriding shutdown
    shutdown = 1; disp_test = 1; scan_limit = 3'd1;
    run_n(8 * SLOT + 3, "R7 lamp test");
    disp_test = 0; shutdown = 0;
    run_n(2 * SLOT, "R7 release");
    // sync mid-slot
    scan_limit = 3'd5; intensity = 4'd6; seg_vec = 8'h5A;
    run_n(SLOT + 11, "R8 pre-sync");
    sync = 1;
    step("R8 sync");
    sync = 0;
    run_n(2 * SLOT, "R8 after sync");
    // minimum code, single digit
    scan_limit = 3'd0; intensity = 4'd0; seg_vec = 8'hFF;
    run_n(3 * SLOT, "R2 R3 single digit code0");
    run_n(2, "drain");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule